// File: doc/BRIEF.md
# Calendar Timekeeper with Committed Time Loads

This block keeps calendar time: seconds, minutes, hours, day of month, day of week, month and year. A one-second tick pulse advances the count. Each rollover cascades upward through the fields. Day-of-month length depends on the month and on a leap-year rule. The year is stored as a 7-bit offset from 1968, and months count from 1.

A host reaches the block over a simple 16-bit register bus. Writes to the time fields do not touch the running count; they land in a staging copy. A separate write of the value 1 to a trigger register copies the whole staging copy into the running count in one step. A busy bit in the control register stays set while that load is in progress, and the host polls it. Reads of the time fields always return the running count, so a reader can take seconds before and after a burst and retry if the value went backwards.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the running time is second 0, minute 0, hour 0, day of month 1, day of week 1, month 1, year offset 0, and the busy bit reads 0.
- R2: Reading byte address 0x0A + 2k returns a running field, zero-extended to 16 bits. k runs 0..6 in the order second, minute, hour, day of month, day of week, month, year. Address 0x00 returns the busy flag in bit 6, with all other bits 0.
- R3: A write to a time-field address while not busy updates only the staging copy, keeping the low bits that fit the field (second/minute 6, hour/day of month 5, day of week 3, month 4, year 7). Reads of that field keep returning the running value.
- R4: A write of exactly 1 to address 0x3C while not busy sets the busy bit for exactly 4 clock cycles after the write edge. On the edge that clears busy, every running field takes its staged value, and that load wins over a tick on the same edge. A write of any other value there starts nothing.
- R5: While busy is set, time-field writes and trigger writes are ignored. The staging copy is unchanged and the busy window is not extended.
- R6: On a tick, seconds advance; 59 wraps to 0 and carries into minutes. Minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day.
- R7: A day carry wraps the day of month to 1 after the month's last day and advances the month. Months 4, 6, 9 and 11 have 30 days, month 2 has 29 when the year offset is divisible by 4 and 28 otherwise, and all others have 31. Month 12 wraps to 1 and advances the year.
- R8: Day of week advances by one on every day carry and wraps from 6 to 0.
- R9: The year offset wraps from 127 to 0 when December 31 rolls over.
- R10: With busy clear, each tick advances the seconds field by exactly one, and with no tick the running time holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i (combinational) |

## Verification
A corrupted staging copy stays hidden until the next trigger. It then shows in every field read on the cycle busy clears, so each load is followed by a full read-back. A faulty rollover rule shows one tick after the boundary as a wrong day, month, year or weekday. Each month-length, leap and wrap case is therefore loaded one second before midnight and read after a single tick. A busy window of the wrong length, or one extended by a repeat trigger, shows in the cycle-by-cycle sampling of the control bit.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DOM_W  = 5;
    localparam int DOW_W  = 3;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  minute;
        logic [HOUR_W-1:0] hour;
        logic [DOM_W-1:0]  mday;
        logic [DOW_W-1:0]  wday;
        logic [MON_W-1:0]  month;
        logic [YEAR_W-1:0] year;
    } cal_t;

    // 1968-01-01 00:00:00, a Monday (0 = Sunday)
    localparam cal_t CAL_RESET = '{sec: '0, minute: '0, hour: '0,
                                   mday: DOM_W'(1), wday: DOW_W'(1),
                                   month: MON_W'(1), year: '0};

    function automatic logic [DOM_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                    input logic [YEAR_W-1:0] yr);
        case (mon)
            MON_W'(2):  return (yr[1:0] == 2'b00) ? DOM_W'(29) : DOM_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DOM_W'(30);
            default:    return DOM_W'(31);
        endcase
    endfunction
endpackage

// File: rtl/cal_advance.sv
`timescale 1ns/1ps
module cal_advance
    import cal_pkg::*;
(
    input  cal_t cur_i,
    output cal_t nxt_o
);
    logic last_day;

    always_comb begin
        nxt_o    = cur_i;
        last_day = (cur_i.mday == month_days(cur_i.month, cur_i.year));
        if (cur_i.sec != SEC_W'(59)) begin
            nxt_o.sec = cur_i.sec + SEC_W'(1);
        end else begin
            nxt_o.sec = '0;
            if (cur_i.minute != MIN_W'(59)) begin
                nxt_o.minute = cur_i.minute + MIN_W'(1);
            end else begin
                nxt_o.minute = '0;
                if (cur_i.hour != HOUR_W'(23)) begin
                    nxt_o.hour = cur_i.hour + HOUR_W'(1);
                end else begin
                    nxt_o.hour = '0;
                    nxt_o.wday = (cur_i.wday == DOW_W'(6)) ? '0 : cur_i.wday + DOW_W'(1);
                    if (!last_day) begin
                        nxt_o.mday = cur_i.mday + DOM_W'(1);
                    end else begin
                        nxt_o.mday = DOM_W'(1);
                        if (cur_i.month != MON_W'(12)) begin
                            nxt_o.month = cur_i.month + MON_W'(1);
                        end else begin
                            nxt_o.month = MON_W'(1);
                            nxt_o.year  = cur_i.year + YEAR_W'(1);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_commit_ctl.sv
`timescale 1ns/1ps
module cal_commit_ctl #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic fire_o
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
        else if (start_i) cnt_d = CNT_W'(BUSY_CYC);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign fire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cal_timekeeper.sv
`timescale 1ns/1ps
module cal_timekeeper
    import cal_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 4,
    parameter int BUSY_BIT = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] TIME_BASE = 'h0A,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h3C
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_SEC  = TIME_BASE;
    localparam logic [ADDR_W-1:0] A_MIN  = TIME_BASE + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_HOUR = TIME_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_MDAY = TIME_BASE + ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_WDAY = TIME_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_MON  = TIME_BASE + ADDR_W'(10);
    localparam logic [ADDR_W-1:0] A_YEAR = TIME_BASE + ADDR_W'(12);

    typedef struct packed {
        cal_t live;
        cal_t shadow;
    } tk_state_t;

    tk_state_t state_d, state_q;
    cal_t      adv;
    cal_t      live_w;
    logic      busy_w, fire_w, trig_start;

    assign trig_start = wr_en_i && (addr_i == TRIG_ADDR) && (wdata_i == DATA_W'(1));
    assign live_w     = state_q.live;

    cal_commit_ctl #(.BUSY_CYC(BUSY_CYC)) u_ctl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(trig_start),
        .busy_o (busy_w),
        .fire_o (fire_w)
    );

    cal_advance u_adv (
        .cur_i(state_q.live),
        .nxt_o(adv)
    );

    always_comb begin
        state_d = state_q;
        if (fire_w)      state_d.live = state_q.shadow;
        else if (tick_i) state_d.live = adv;
        if (wr_en_i && !busy_w) begin
            case (addr_i)
                A_SEC:   state_d.shadow.sec    = wdata_i[SEC_W-1:0];
                A_MIN:   state_d.shadow.minute = wdata_i[MIN_W-1:0];
                A_HOUR:  state_d.shadow.hour   = wdata_i[HOUR_W-1:0];
                A_MDAY:  state_d.shadow.mday   = wdata_i[DOM_W-1:0];
                A_WDAY:  state_d.shadow.wday   = wdata_i[DOW_W-1:0];
                A_MON:   state_d.shadow.month  = wdata_i[MON_W-1:0];
                A_YEAR:  state_d.shadow.year   = wdata_i[YEAR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.live   <= CAL_RESET;
            state_q.shadow <= CAL_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            CTRL_ADDR: rdata_o[BUSY_BIT] = busy_w;
            A_SEC:     rdata_o = DATA_W'(state_q.live.sec);
            A_MIN:     rdata_o = DATA_W'(state_q.live.minute);
            A_HOUR:    rdata_o = DATA_W'(state_q.live.hour);
            A_MDAY:    rdata_o = DATA_W'(state_q.live.mday);
            A_WDAY:    rdata_o = DATA_W'(state_q.live.wday);
            A_MON:     rdata_o = DATA_W'(state_q.live.month);
            A_YEAR:    rdata_o = DATA_W'(state_q.live.year);
            default:   ;
        endcase
    end
endmodule

// File: rtl/cal_timekeeper_chk.sv
`timescale 1ns/1ps
module cal_timekeeper_chk
    import cal_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 4,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h3C
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              busy_i,
    input cal_t              live_i
);
    localparam int RUN_W = $clog2(BUSY_CYC + 1) + 1;

    logic [RUN_W-1:0] run_q;
    logic             accept;

    assign accept = wr_en_i && (addr_i == TRIG_ADDR) && (wdata_i == DATA_W'(1)) && !busy_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                           run_q <= '0;
        else if (!busy_i)                      run_q <= '0;
        else if (run_q != {RUN_W{1'b1}})       run_q <= run_q + RUN_W'(1);
    end

    p_trigger_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> busy_i);

    p_busy_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> (run_q < RUN_W'(BUSY_CYC)));

    p_busy_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_i) |-> (run_q == RUN_W'(BUSY_CYC)));

    p_clock_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_i.sec <= SEC_W'(59)) && (live_i.minute <= MIN_W'(59)) &&
        (live_i.hour <= HOUR_W'(23)));

    p_date_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i || ((live_i.month >= MON_W'(1)) && (live_i.month <= MON_W'(12)) &&
        (live_i.mday >= DOM_W'(1)) && (live_i.mday <= month_days(live_i.month, live_i.year))));

    p_wday_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i || (live_i.wday <= DOW_W'(6)));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !busy_i) |=> $stable(live_i));

    p_sec_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !busy_i && (live_i.sec != SEC_W'(59))) |=>
        (live_i.sec == $past(live_i.sec) + SEC_W'(1)));
endmodule

bind cal_timekeeper cal_timekeeper_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BUSY_CYC (BUSY_CYC),
    .TRIG_ADDR(TRIG_ADDR)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .busy_i (busy_w),
    .live_i (live_w)
);

// File: tb/tb_cal_timekeeper.sv
`timescale 1ns/1ps
module tb_cal_timekeeper;
    localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h0A, A_MIN = 8'h0C, A_HOUR = 8'h0E,
                           A_MDAY = 8'h10, A_WDAY = 8'h12, A_MON = 8'h14, A_YEAR = 8'h16,
                           A_TRIG = 8'h3C;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    cal_timekeeper dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic chk_busy(input string req, input int exp);
        int v;
        rd(A_CTRL, v);
        chk(req, "busy bit6", (v >> 6) & 1, exp);
        chk(req, "ctrl other bits", v & 16'hFFBF, 0);
    endtask

    task automatic chk_time(input string req, input int s, input int mi, input int h,
                            input int d, input int w, input int mo, input int y);
        int v;
        rd(A_SEC, v);  chk(req, "sec", v, s);
        rd(A_MIN, v);  chk(req, "minute", v, mi);
        rd(A_HOUR, v); chk(req, "hour", v, h);
        rd(A_MDAY, v); chk(req, "mday", v, d);
        rd(A_WDAY, v); chk(req, "wday", v, w);
        rd(A_MON, v);  chk(req, "month", v, mo);
        rd(A_YEAR, v); chk(req, "year", v, y);
    endtask

    task automatic stage(input int s, input int mi, input int h, input int d,
                         input int w, input int mo, input int y);
        wr(A_SEC, 16'(s));  wr(A_MIN, 16'(mi)); wr(A_HOUR, 16'(h));
        wr(A_MDAY, 16'(d)); wr(A_WDAY, 16'(w)); wr(A_MON, 16'(mo));
        wr(A_YEAR, 16'(y));
    endtask

    task automatic load(input int s, input int mi, input int h, input int d,
                        input int w, input int mo, input int y);
        stage(s, mi, h, d, w, mo, y);
        wr(A_TRIG, 16'd1);
        repeat (4) @(negedge clk);
    endtask

    // Load 23:59:59 on a date, tick once, expect the next date
    task automatic roll_day(input string req, input int d, input int mo, input int y,
                            input int w, input int ed, input int emo, input int ey);
        load(59, 59, 23, d, w, mo, y);
        pulse_tick();
        chk_time(req, 0, 0, 0, ed, (w + 1) % 7, emo, ey);
    endtask

    task automatic t_reset();
        chk_busy("R1", 0);
        chk_time("R1", 0, 0, 0, 1, 1, 1, 0);
        begin
            int v;
            rd(8'h08, v); chk("R2", "unmapped read", v, 0);
        end
    endtask

    task automatic t_tick();
        repeat (5) pulse_tick();
        chk_time("R10", 5, 0, 0, 1, 1, 1, 0);
        repeat (10) @(negedge clk);
        chk_time("R10", 5, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_stage();
        wr(A_SEC, 16'hFFDE);
        wr(A_MIN, 16'd7);
        wr(A_HOUR, 16'd3);
        chk_time("R3", 5, 0, 0, 1, 1, 1, 0);
    endtask

    task automatic t_commit();
        int v;
        wr(A_MDAY, 16'd9); wr(A_WDAY, 16'd2); wr(A_MON, 16'd6); wr(A_YEAR, 16'd20);
        wr(A_TRIG, 16'd1);
        for (int k = 0; k < 4; k++) begin
            chk_busy("R4", 1);
            if (k == 3) begin
                rd(A_SEC, v); chk("R4", "sec before load", v, 5);
            end
            @(negedge clk);
        end
        chk_busy("R4", 0);
        // staged sec 0xFFDE keeps its low 6 bits: 30
        chk_time("R4", 30, 7, 3, 9, 2, 6, 20);
    endtask

    task automatic t_bad_trigger();
        wr(A_SEC, 16'd50);
        wr(A_TRIG, 16'd2);
        chk_busy("R4", 0);
        repeat (6) @(negedge clk);
        chk_time("R4", 30, 7, 3, 9, 2, 6, 20);
    endtask

    task automatic t_busy_ignore();
        stage(10, 1, 2, 3, 4, 5, 6);
        wr(A_TRIG, 16'd1);
        wr(A_SEC, 16'd40);
        wr(A_TRIG, 16'd1);
        chk_busy("R5", 0);
        chk_time("R5", 10, 1, 2, 3, 4, 5, 6);
        wr(A_TRIG, 16'd1);
        repeat (4) @(negedge clk);
        chk_time("R5", 10, 1, 2, 3, 4, 5, 6);
    endtask

    task automatic t_rollover();
        load(58, 59, 23, 15, 2, 3, 0);
        pulse_tick();
        chk_time("R6", 59, 59, 23, 15, 2, 3, 0);
        pulse_tick();
        chk_time("R6", 0, 0, 0, 16, 3, 3, 0);
        load(59, 10, 5, 4, 1, 8, 9);
        pulse_tick();
        chk_time("R6", 0, 11, 5, 4, 1, 8, 9);
        load(59, 59, 5, 4, 1, 8, 9);
        pulse_tick();
        chk_time("R6", 0, 0, 6, 4, 1, 8, 9);
    endtask

    task automatic t_month_ends();
        roll_day("R7", 30, 4, 5, 0, 1, 5, 5);
        roll_day("R7", 30, 1, 5, 1, 31, 1, 5);
        roll_day("R7", 31, 1, 5, 2, 1, 2, 5);
        roll_day("R7", 28, 2, 4, 3, 29, 2, 4);
        roll_day("R7", 29, 2, 4, 4, 1, 3, 4);
        roll_day("R7", 28, 2, 5, 5, 1, 3, 5);
        roll_day("R7", 30, 6, 0, 0, 1, 7, 0);
        roll_day("R7", 30, 9, 1, 1, 1, 10, 1);
        roll_day("R7", 30, 11, 2, 2, 1, 12, 2);
        roll_day("R7", 30, 12, 2, 3, 31, 12, 2);
        roll_day("R7", 31, 12, 10, 3, 1, 1, 11);
    endtask

    task automatic t_wday_wrap();
        roll_day("R8", 10, 3, 3, 6, 11, 3, 3);
    endtask

    task automatic t_year_wrap();
        roll_day("R9", 31, 12, 127, 5, 1, 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick();
        t_stage();
        t_commit();
        t_bad_trigger();
        t_busy_ignore();
        t_rollover();
        t_month_ends();
        t_wday_wrap();
        t_year_wrap();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule